// File: doc/BRIEF.md
# ATAPI Power-Up Initialisation Sequencer

This block brings an ATAPI packet device from power-up to a usable state without processor help. It runs a fixed program of register accesses through a separate PIO access engine: a soft reset through the device-control register, a device reset command, and an identify-packet-device command whose 512-byte reply is drained and thrown away. After that it sends a table-of-contents packet command, and it keeps retrying that command until the device accepts it.

The block talks to the access engine through one request/acknowledge pair. A request carries a 4-bit register address, a write flag and 16 bits of write data. The engine answers with a single-cycle acknowledge, together with read data zero-extended to 16 bits. All waits are clock counts set by parameters, so a simulation can use short values and silicon can use the real millisecond intervals. The block raises `init_done` when the table-of-contents reply has been read. It raises a sticky `init_err` if any check of device state failed along the way.

Register addresses on `acc_addr` are 0 for data, 1 for features, 4 for byte-count low, 5 for byte-count high, 6 for drive select and 7 for command on writes or status on reads. Address 8 is device control; bit 3 of the address selects the control block.

Top module: `ata_init_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `acc_req`, `init_done` and `init_err` are 0 after that edge.
- R2: Once `acc_req` rises, it stays high with `acc_we`, `acc_addr` and `acc_wdata` unchanged until the cycle in which `acc_ack` is seen. It is low in the following cycle.
- R3: The first accesses write 0x0C to address 8, then write 0x08 to address 8. A wait of RESET_WAIT cycles comes after each write, and then status is polled.
- R4: Next comes a write of 0x08 to address 7 (device reset command), a wait of CMD_WAIT cycles, and a poll of status.
- R5: Next come writes of 0xA0 to address 6 and 0xA1 to address 7, a poll, and a wait of CMD_WAIT cycles. Status is then read. If status bit 3 (DRQ) is 0, the identify reply is skipped and the error flag is set.
- R6: After a good DRQ, byte-count high (address 5) must read 0x0002 and byte-count low (address 4) must read 0x0000. If so, exactly ID_WORDS (256) reads of address 0 follow. Otherwise no data is read and the error flag is set.
- R7: Each table-of-contents attempt runs these steps in order. It polls, then writes 0 to address 1, 0 to address 4, 0x06 to address 5, 0xA0 to address 6 and 0xA0 to address 7. It polls and checks DRQ. It writes the six packet words 0x0243, 0x0000, 0x0000, 0x0400, 0x8050 and 0x0000 to address 0. It polls and checks DRQ. It checks that byte-count high is 0x0000 and byte-count low is 0x0030. Finally it reads TOC_WORDS (24) words from address 0.
- R8: Any failed check in a table-of-contents attempt sets the error flag. The block then waits RETRY_WAIT cycles and starts a new attempt with its poll.
- R9: `init_done` rises only after the last table-of-contents word is read. It then stays high until reset, and no further request is made.
- R10: `init_err` stays high from the first failed check until reset.
- R11: A poll re-reads status (address 7) while status bit 7 (BSY) reads 1. No other access comes between a busy status read and the next status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_req | output | 1 | Access request to the PIO engine |
| acc_we | output | 1 | 1 = register write, 0 = register read |
| acc_addr | output | 4 | Register address (bit 3 = control block) |
| acc_wdata | output | 16 | Write data |
| acc_ack | input | 1 | One-cycle completion pulse from the engine |
| acc_rdata | input | 16 | Read data, valid with `acc_ack` |
| init_done | output | 1 | Initialisation complete |
| init_err | output | 1 | Sticky flag: a device check failed |

## Verification
The handshake assertions assume that the engine pulses `acc_ack` for a single cycle, only while a request is pending, with read data valid in that same cycle. The bench's device responder follows this rule. It acknowledges a pending request after a latency chosen for each scenario, then drops the acknowledge at once. The responder also holds BSY for a chosen number of status reads after each command. It returns DRQ and byte counts taken from the scenario table, so every path the sequencer takes is one a conforming engine and device could produce.

// File: rtl/ata_init_pkg.sv
// Package: shared types for the ATAPI init sequencer.
// Assumes a 4-bit register address space with the control block at bit 3.
package ata_init_pkg;

    localparam int PC_W  = 6;
    localparam int ARG_W = 9;

    // Register addresses presented to the PIO access engine
    localparam logic [3:0] ADR_DATA   = 4'h0;
    localparam logic [3:0] ADR_FEAT   = 4'h1;
    localparam logic [3:0] ADR_CNT_LO = 4'h4;
    localparam logic [3:0] ADR_CNT_HI = 4'h5;
    localparam logic [3:0] ADR_SELECT = 4'h6;
    localparam logic [3:0] ADR_CMD    = 4'h7;
    localparam logic [3:0] ADR_DEVCTL = 4'h8;

    // Status bit positions
    localparam int STAT_BUSY = 7;
    localparam int STAT_XFER = 3;

    typedef enum logic [2:0] {
        OP_WRITE,
        OP_DELAY,
        OP_POLL,
        OP_CHK_DRQ,
        OP_CHK_EQ,
        OP_READN,
        OP_JUMP,
        OP_FINISH
    } op_e;

    typedef enum logic [1:0] {
        DLY_RESET = 2'd0,
        DLY_CMD   = 2'd1,
        DLY_RETRY = 2'd2
    } dly_e;

    // One program step: operation, register, data/compare value, argument
    typedef struct packed {
        op_e               op;
        logic [3:0]        addr;
        logic [15:0]       data;
        logic [ARG_W-1:0]  arg;
    } uop_t;

    typedef enum logic [1:0] {
        ST_DECODE,
        ST_ACCESS,
        ST_DELAY,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/ata_init_rom.sv
// Module: ata_init_rom
// The fixed init program as combinational decode of the program counter.
// The arg field holds the failure or jump target for checks and jumps, the
// word count for bulk reads, and the delay selector for waits.
// Assumes ID_WORDS and TOC_WORDS fit in ARG_W bits.
module ata_init_rom
    import ata_init_pkg::*;
#(
    parameter int ID_WORDS  = 256,
    parameter int TOC_WORDS = 24
) (
    input  logic [PC_W-1:0] pc,
    output uop_t            uop
);

    localparam logic [ARG_W-1:0] L_TOC   = ARG_W'(16);
    localparam logic [ARG_W-1:0] L_RETRY = ARG_W'(36);
    localparam logic [ARG_W-1:0] N_ID    = ARG_W'(ID_WORDS);
    localparam logic [ARG_W-1:0] N_TOC   = ARG_W'(TOC_WORDS);

    // Build one program step
    function automatic uop_t mk(op_e o, logic [3:0] a, logic [15:0] d,
                                logic [ARG_W-1:0] g);
        uop_t u;
        u.op   = o;
        u.addr = a;
        u.data = d;
        u.arg  = g;
        return u;
    endfunction

    // Program listing, one step per program counter value
    always_comb begin
        case (pc)
            6'd0:  uop = mk(OP_WRITE,   ADR_DEVCTL, 16'h000C, '0);
            6'd1:  uop = mk(OP_DELAY,   4'h0, 16'h0, ARG_W'(DLY_RESET));
            6'd2:  uop = mk(OP_WRITE,   ADR_DEVCTL, 16'h0008, '0);
            6'd3:  uop = mk(OP_DELAY,   4'h0, 16'h0, ARG_W'(DLY_RESET));
            6'd4:  uop = mk(OP_POLL,    ADR_CMD, 16'h0, '0);
            6'd5:  uop = mk(OP_WRITE,   ADR_CMD, 16'h0008, '0);
            6'd6:  uop = mk(OP_DELAY,   4'h0, 16'h0, ARG_W'(DLY_CMD));
            6'd7:  uop = mk(OP_POLL,    ADR_CMD, 16'h0, '0);
            6'd8:  uop = mk(OP_WRITE,   ADR_SELECT, 16'h00A0, '0);
            6'd9:  uop = mk(OP_WRITE,   ADR_CMD, 16'h00A1, '0);
            6'd10: uop = mk(OP_POLL,    ADR_CMD, 16'h0, '0);
            6'd11: uop = mk(OP_DELAY,   4'h0, 16'h0, ARG_W'(DLY_CMD));
            6'd12: uop = mk(OP_CHK_DRQ, ADR_CMD, 16'h0, L_TOC);
            6'd13: uop = mk(OP_CHK_EQ,  ADR_CNT_HI, 16'h0002, L_TOC);
            6'd14: uop = mk(OP_CHK_EQ,  ADR_CNT_LO, 16'h0000, L_TOC);
            6'd15: uop = mk(OP_READN,   ADR_DATA, 16'h0, N_ID);
            6'd16: uop = mk(OP_POLL,    ADR_CMD, 16'h0, '0);
            6'd17: uop = mk(OP_WRITE,   ADR_FEAT, 16'h0000, '0);
            6'd18: uop = mk(OP_WRITE,   ADR_CNT_LO, 16'h0000, '0);
            6'd19: uop = mk(OP_WRITE,   ADR_CNT_HI, 16'h0006, '0);
            6'd20: uop = mk(OP_WRITE,   ADR_SELECT, 16'h00A0, '0);
            6'd21: uop = mk(OP_WRITE,   ADR_CMD, 16'h00A0, '0);
            6'd22: uop = mk(OP_POLL,    ADR_CMD, 16'h0, '0);
            6'd23: uop = mk(OP_CHK_DRQ, ADR_CMD, 16'h0, L_RETRY);
            6'd24: uop = mk(OP_WRITE,   ADR_DATA, 16'h0243, '0);
            6'd25: uop = mk(OP_WRITE,   ADR_DATA, 16'h0000, '0);
            6'd26: uop = mk(OP_WRITE,   ADR_DATA, 16'h0000, '0);
            6'd27: uop = mk(OP_WRITE,   ADR_DATA, 16'h0400, '0);
            6'd28: uop = mk(OP_WRITE,   ADR_DATA, 16'h8050, '0);
            6'd29: uop = mk(OP_WRITE,   ADR_DATA, 16'h0000, '0);
            6'd30: uop = mk(OP_POLL,    ADR_CMD, 16'h0, '0);
            6'd31: uop = mk(OP_CHK_DRQ, ADR_CMD, 16'h0, L_RETRY);
            6'd32: uop = mk(OP_CHK_EQ,  ADR_CNT_HI, 16'h0000, L_RETRY);
            6'd33: uop = mk(OP_CHK_EQ,  ADR_CNT_LO, 16'h0030, L_RETRY);
            6'd34: uop = mk(OP_READN,   ADR_DATA, 16'h0, N_TOC);
            6'd35: uop = mk(OP_FINISH,  4'h0, 16'h0, '0);
            6'd36: uop = mk(OP_DELAY,   4'h0, 16'h0, ARG_W'(DLY_RETRY));
            6'd37: uop = mk(OP_JUMP,    4'h0, 16'h0, L_TOC);
            default: uop = mk(OP_FINISH, 4'h0, 16'h0, '0);
        endcase
    end

endmodule

// File: rtl/ata_init_timer.sv
// Module: ata_init_timer
// One-shot wait counter with three selectable lengths. A start pulse loads
// the chosen length; busy stays high for that many cycles and done marks
// the last of them. Assumes every length is at least 1 and that start
// never arrives while busy.
module ata_init_timer
    import ata_init_pkg::*;
#(
    parameter int RESET_WAIT = 1000,
    parameter int CMD_WAIT   = 500,
    parameter int RETRY_WAIT = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] sel,
    output logic       busy,
    output logic       done
);

    localparam int MAX_A = (RESET_WAIT > CMD_WAIT) ? RESET_WAIT : CMD_WAIT;
    localparam int MAX_W = (MAX_A > RETRY_WAIT) ? MAX_A : RETRY_WAIT;
    localparam int CW    = $clog2(MAX_W + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] len;

    // Pick the wait length for the requested interval
    always_comb begin
        case (sel)
            DLY_RESET: len = CW'(RESET_WAIT);
            DLY_CMD:   len = CW'(CMD_WAIT);
            default:   len = CW'(RETRY_WAIT);
        endcase
    end

    // Load on start, count down while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= len - 1'b1;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R3

    AST_WAIT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R4

endmodule

// File: rtl/ata_init_seq.sv
// Module: ata_init_seq (top)
// Runs the ATAPI power-up program against a PIO access engine: soft reset,
// device reset, identify drain, then table-of-contents reads until one
// succeeds. Assumes acc_ack is a single-cycle pulse given only while
// acc_req is high, with acc_rdata valid in that cycle (zero-extended bytes).
module ata_init_seq
    import ata_init_pkg::*;
#(
    parameter int RESET_WAIT = 1000,
    parameter int CMD_WAIT   = 500,
    parameter int RETRY_WAIT = 100,
    parameter int ID_WORDS   = 256,
    parameter int TOC_WORDS  = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        acc_req,
    output logic        acc_we,
    output logic [3:0]  acc_addr,
    output logic [15:0] acc_wdata,
    input  logic        acc_ack,
    input  logic [15:0] acc_rdata,
    output logic        init_done,
    output logic        init_err
);

    localparam int MAX_WORDS = (ID_WORDS > TOC_WORDS) ? ID_WORDS : TOC_WORDS;

    seq_state_e        state;
    logic [PC_W-1:0]   pc;
    logic [ARG_W-1:0]  wcnt;
    uop_t              uop;
    logic              tmr_start;
    logic              tmr_busy;
    logic              tmr_done;
    logic [PC_W-1:0]   pc_next;
    logic [PC_W-1:0]   pc_fail;

    ata_init_rom #(
        .ID_WORDS (ID_WORDS),
        .TOC_WORDS(TOC_WORDS)
    ) u_rom (
        .pc (pc),
        .uop(uop)
    );

    ata_init_timer #(
        .RESET_WAIT(RESET_WAIT),
        .CMD_WAIT  (CMD_WAIT),
        .RETRY_WAIT(RETRY_WAIT)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_start),
        .sel  (uop.arg[1:0]),
        .busy (tmr_busy),
        .done (tmr_done)
    );

    // Start the wait timer when a delay step is decoded
    always_comb begin
        tmr_start = (state == ST_DECODE) && (uop.op == OP_DELAY);
        pc_next   = pc + 1'b1;
        pc_fail   = uop.arg[PC_W-1:0];
    end

    // Program execution: decode a step, run its access or wait, advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_DECODE;
            pc        <= '0;
            wcnt      <= '0;
            acc_req   <= 1'b0;
            acc_we    <= 1'b0;
            acc_addr  <= '0;
            acc_wdata <= '0;
            init_done <= 1'b0;
            init_err  <= 1'b0;
        end else begin
            case (state)
                ST_DECODE: begin
                    case (uop.op)
                        OP_WRITE: begin
                            acc_req   <= 1'b1;
                            acc_we    <= 1'b1;
                            acc_addr  <= uop.addr;
                            acc_wdata <= uop.data;
                            state     <= ST_ACCESS;
                        end
                        OP_POLL, OP_CHK_DRQ, OP_CHK_EQ: begin
                            acc_req   <= 1'b1;
                            acc_we    <= 1'b0;
                            acc_addr  <= uop.addr;
                            acc_wdata <= '0;
                            state     <= ST_ACCESS;
                        end
                        OP_READN: begin
                            if (wcnt == uop.arg) begin
                                wcnt <= '0;
                                pc   <= pc_next;
                            end else begin
                                acc_req   <= 1'b1;
                                acc_we    <= 1'b0;
                                acc_addr  <= ADR_DATA;
                                acc_wdata <= '0;
                                state     <= ST_ACCESS;
                            end
                        end
                        OP_DELAY: state <= ST_DELAY;
                        OP_JUMP:  pc    <= pc_fail;
                        default: begin
                            init_done <= 1'b1;
                            state     <= ST_DONE;
                        end
                    endcase
                end
                ST_ACCESS: begin
                    if (acc_ack) begin
                        acc_req <= 1'b0;
                        state   <= ST_DECODE;
                        case (uop.op)
                            OP_POLL: begin
                                if (!acc_rdata[STAT_BUSY]) pc <= pc_next;
                            end
                            OP_CHK_DRQ: begin
                                if (acc_rdata[STAT_XFER]) begin
                                    pc <= pc_next;
                                end else begin
                                    pc       <= pc_fail;
                                    init_err <= 1'b1;
                                end
                            end
                            OP_CHK_EQ: begin
                                if (acc_rdata == uop.data) begin
                                    pc <= pc_next;
                                end else begin
                                    pc       <= pc_fail;
                                    init_err <= 1'b1;
                                end
                            end
                            OP_READN: wcnt <= wcnt + 1'b1;
                            default:  pc   <= pc_next;
                        endcase
                    end
                end
                ST_DELAY: begin
                    if (tmr_done) begin
                        pc    <= pc_next;
                        state <= ST_DECODE;
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_ack |=> acc_req && $stable(acc_we) && $stable(acc_addr)
                                 && $stable(acc_wdata)); // R2

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ack |=> !acc_req); // R2

    AST_NO_REQ_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !acc_req); // R3

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done && !acc_req); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> init_err); // R10

    AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= ARG_W'(MAX_WORDS)); // R6

    AST_BUSY_REPOLL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack && (uop.op == OP_POLL) && acc_rdata[STAT_BUSY]
        |=> $stable(pc)); // R11

endmodule

// File: tb/ata_init_seq_test.sv
// Bench: a device responder answers the sequencer's accesses from a
// scenario table; each row is run from reset and its counts are compared.
module ata_init_seq_test;

    localparam int RW = 40;
    localparam int CW = 20;
    localparam int TW = 30;

    typedef struct packed {
        logic [3:0] lat;
        logic [3:0] bsy;
        logic       drq;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [3:0] fails;
        logic       exp_err;
        logic [8:0] exp_id;
    } scn_t;

    localparam scn_t SCN [0:5] = '{
        '{4'd1, 4'd0, 1'b1, 8'h02, 8'h00, 4'd0, 1'b0, 9'd256},
        '{4'd3, 4'd2, 1'b1, 8'h02, 8'h00, 4'd2, 1'b1, 9'd256},
        '{4'd2, 4'd1, 1'b0, 8'h02, 8'h00, 4'd0, 1'b1, 9'd0},
        '{4'd1, 4'd0, 1'b1, 8'h04, 8'h00, 4'd0, 1'b1, 9'd0},
        '{4'd0, 4'd3, 1'b1, 8'h02, 8'h10, 4'd1, 1'b1, 9'd0},
        '{4'd2, 4'd3, 1'b1, 8'h02, 8'h00, 4'd1, 1'b1, 9'd256}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req, acc_we, acc_ack, init_done, init_err;
    logic [3:0]  acc_addr;
    logic [15:0] acc_wdata, acc_rdata;

    always #5 clk = ~clk;

    ata_init_seq #(
        .RESET_WAIT(RW), .CMD_WAIT(CW), .RETRY_WAIT(TW),
        .ID_WORDS(256), .TOC_WORDS(24)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_rdata(acc_rdata),
        .init_done(init_done), .init_err(init_err)
    );

    // responder and monitor state
    scn_t cfg;
    logic clr = 1'b1;
    int   wait_cnt, bsy_left, phase, toc_try, id_rd, toc_rd;
    int   pkt_words, pkt_total, pkt_bad, bsy_viol, hold_viol, late_req;
    int   dc_n, cyc, t_dc, t_cmd, t_fail, gap_rst, gap_cmd, gap_retry;
    logic [7:0]  dc0, dc1;
    logic        last_bsy, cmd_pend, fail_pend, dc_pend;
    logic        prev_req, prev_ack, prev_we;
    logic [3:0]  prev_addr;
    logic [15:0] prev_wdata;
    logic [15:0] rd;
    int   n_chk = 0;
    int   n_fail = 0;

    function automatic logic [15:0] pkt_exp(input int i);
        case (i)
            0: return 16'h0243;
            3: return 16'h0400;
            4: return 16'h8050;
            default: return 16'h0000;
        endcase
    endfunction

    // Device responder: acks pending requests after cfg.lat cycles
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (clr) begin
            wait_cnt = 0; bsy_left = 0; phase = 0; toc_try = 0; id_rd = 0;
            toc_rd = 0; pkt_words = 0; pkt_total = 0; pkt_bad = 0;
            bsy_viol = 0; hold_viol = 0; late_req = 0; dc_n = 0;
            dc0 = 8'h0; dc1 = 8'h0; last_bsy = 1'b0; cmd_pend = 1'b0;
            fail_pend = 1'b0; dc_pend = 1'b0; gap_rst = -1; gap_cmd = -1;
            gap_retry = -1; t_dc = 0; t_cmd = 0; t_fail = 0;
            prev_req = 1'b0; prev_ack = 1'b0;
            acc_ack <= 1'b0; acc_rdata <= 16'h0;
        end else begin
            if (prev_req && !prev_ack && rst_n &&
                (!acc_req || acc_we != prev_we || acc_addr != prev_addr ||
                 acc_wdata != prev_wdata))
                hold_viol = hold_viol + 1;
            if (acc_req && !prev_req) begin
                if (dc_pend && acc_we && acc_addr == 4'h8) begin
                    gap_rst = cyc - t_dc; dc_pend = 1'b0;
                end
                if (cmd_pend) begin gap_cmd = cyc - t_cmd; cmd_pend = 1'b0; end
                if (fail_pend) begin gap_retry = cyc - t_fail; fail_pend = 1'b0; end
            end
            prev_req = acc_req; prev_ack = acc_ack; prev_we = acc_we;
            prev_addr = acc_addr; prev_wdata = acc_wdata;
            if (acc_ack) begin
                acc_ack <= 1'b0;
            end else if (acc_req) begin
                if (wait_cnt < int'(cfg.lat)) begin
                    wait_cnt = wait_cnt + 1;
                end else begin
                    wait_cnt = 0;
                    rd = 16'h0;
                    if (init_done) late_req = late_req + 1;
                    if (last_bsy && (acc_we || acc_addr != 4'h7))
                        bsy_viol = bsy_viol + 1;
                    last_bsy = 1'b0;
                    if (acc_we) begin
                        case (acc_addr)
                            4'h8: begin
                                if (dc_n == 0) dc0 = acc_wdata[7:0];
                                if (dc_n == 1) dc1 = acc_wdata[7:0];
                                dc_n = dc_n + 1;
                                if (acc_wdata == 16'h000C) begin
                                    t_dc = cyc; dc_pend = 1'b1;
                                end
                                if (acc_wdata == 16'h0008) bsy_left = int'(cfg.bsy);
                            end
                            4'h7: begin
                                bsy_left = int'(cfg.bsy);
                                if (acc_wdata == 16'h0008) begin
                                    t_cmd = cyc; cmd_pend = 1'b1;
                                end
                                if (acc_wdata == 16'h00A1) phase = 1;
                                if (acc_wdata == 16'h00A0) begin
                                    phase = 2; toc_try = toc_try + 1; pkt_words = 0;
                                end
                            end
                            4'h0: begin
                                if (acc_wdata != pkt_exp(pkt_words % 6))
                                    pkt_bad = pkt_bad + 1;
                                pkt_words = pkt_words + 1;
                                pkt_total = pkt_total + 1;
                            end
                            default: ;
                        endcase
                    end else begin
                        case (acc_addr)
                            4'h7: begin
                                if (bsy_left > 0) begin
                                    rd = 16'h0080; bsy_left = bsy_left - 1;
                                    last_bsy = 1'b1;
                                end else if (phase == 1) begin
                                    rd = cfg.drq ? 16'h0048 : 16'h0040;
                                end else if (phase == 2) begin
                                    rd = 16'h0048;
                                end else begin
                                    rd = 16'h0040;
                                end
                            end
                            4'h5: rd = (phase == 1) ? {8'h0, cfg.hi} : 16'h0;
                            4'h4: begin
                                if (phase == 1) rd = {8'h0, cfg.lo};
                                else if (toc_try <= int'(cfg.fails)) begin
                                    rd = 16'h0020; t_fail = cyc; fail_pend = 1'b1;
                                end else rd = 16'h0030;
                            end
                            4'h0: begin
                                rd = 16'h5A00 ^ 16'(cyc);
                                if (phase == 1) id_rd = id_rd + 1;
                                else if (phase == 2) toc_rd = toc_rd + 1;
                            end
                            default: rd = 16'h0;
                        endcase
                    end
                    acc_rdata <= rd;
                    acc_ack   <= 1'b1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_scn(input scn_t s);
        @(negedge clk);
        cfg = s; clr = 1'b1; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        clr = 1'b0; rst_n = 1'b1;
    endtask

    task automatic wait_done(output bit ok);
        int n = 0;
        while (!init_done && n < 20000) begin
            @(negedge clk);
            n = n + 1;
        end
        ok = init_done;
    endtask

    bit got;

    initial begin
        cfg = SCN[0];
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(acc_req == 1'b0, "R1 reset acc_req", int'(acc_req), 0);
        chk(init_done == 1'b0, "R1 reset init_done", int'(init_done), 0);
        chk(init_err == 1'b0, "R1 reset init_err", int'(init_err), 0);

        // Table walk
        for (int i = 0; i < 6; i++) begin
            start_scn(SCN[i]);
            wait_done(got);
            chk(got, $sformatf("R9 scn%0d done (watchdog)", i), int'(got), 1);
            repeat (30) @(negedge clk);
            chk(init_done == 1'b1, $sformatf("R9 scn%0d done held", i), int'(init_done), 1);
            chk(late_req == 0, $sformatf("R9 scn%0d requests after done", i), late_req, 0);
            chk(init_err == SCN[i].exp_err, $sformatf("R10 scn%0d error flag", i),
                int'(init_err), int'(SCN[i].exp_err));
            chk(id_rd == int'(SCN[i].exp_id), $sformatf("R5 R6 scn%0d identify words", i),
                id_rd, int'(SCN[i].exp_id));
            chk(toc_rd == 24, $sformatf("R7 scn%0d toc words", i), toc_rd, 24);
            chk(toc_try == int'(SCN[i].fails) + 1, $sformatf("R8 scn%0d toc attempts", i),
                toc_try, int'(SCN[i].fails) + 1);
            chk(pkt_total == 6 * toc_try && pkt_bad == 0,
                $sformatf("R7 scn%0d packet words (bad=%0d)", i, pkt_bad),
                pkt_total, 6 * toc_try);
            chk(dc_n == 2 && dc0 == 8'h0C && dc1 == 8'h08,
                $sformatf("R3 scn%0d devctl writes %0h/%0h", i, dc0, dc1), dc_n, 2);
            chk(gap_rst >= RW && gap_rst <= RW + 8, $sformatf("R3 scn%0d reset wait", i),
                gap_rst, RW + 4);
            chk(gap_cmd >= CW && gap_cmd <= CW + 8, $sformatf("R4 scn%0d command wait", i),
                gap_cmd, CW + 4);
            if (SCN[i].fails != 0)
                chk(gap_retry >= TW && gap_retry <= TW + 8,
                    $sformatf("R8 scn%0d retry wait", i), gap_retry, TW + 5);
            chk(bsy_viol == 0, $sformatf("R11 scn%0d busy polling", i), bsy_viol, 0);
            chk(hold_viol == 0, $sformatf("R2 scn%0d request hold", i), hold_viol, 0);
        end

        // Directed: reset in mid-run clears everything
        start_scn(SCN[2]);
        repeat (400) @(negedge clk);
        chk(init_err == 1'b1, "R10 err set mid-run", int'(init_err), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(acc_req == 1'b0, "R1 mid-run reset acc_req", int'(acc_req), 0);
        chk(init_err == 1'b0, "R1 mid-run reset init_err", int'(init_err), 0);
        chk(init_done == 1'b0, "R1 mid-run reset init_done", int'(init_done), 0);
        start_scn(SCN[0]);
        wait_done(got);
        chk(got && !init_err, "R9 clean run after reset", int'(init_err), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule